// File: doc/BRIEF.md
# Palette Write Port with Index Auto-Increment

This block is the host-side write interface to a bank of eight colour palettes, each holding 256 entries. Every entry stores a 9-bit colour (three bits each of red, green and blue) and one priority flag. A host writes four byte-wide registers through a synchronous select/strobe/data bus: an entry pointer, a control byte, a one-byte colour register and a two-byte colour register. From these the block forms the palette storage write address, word and strobe. It also moves the pointer forward after each completed colour write, and tracks which half of the two-byte colour write comes next.

The two-byte path is run by a two-state phase machine. `PH_FIRST` waits for the first byte. On a write to the two-byte colour register it holds that byte and takes the transition `LATCH_HIGH` to `PH_SECOND`. In `PH_SECOND`, a further write to that register commits the entry and takes `COMMIT` back to `PH_FIRST`. A write to any other register takes `ABANDON` back to `PH_FIRST` and drops the held byte. All other events leave the state where it is (`HOLD`). Any register can be read back. The value appears on `rdata` one clock after the read strobe and stays there until the next read.

Top module: `palette_port`

## Requirements
- R1: After reset the entry pointer and the control byte read back as 0, `rdata` is 0, and the two-byte path is in its first phase.
- R2: A write to the one-byte colour register (select 2) with byte C stores colour {C, C[1] OR C[0]} at the selected entry and clears that entry's priority flag.
- R3: After each committed colour write the pointer goes up by one and wraps from 255 to 0. It does not move when control bit 7 is 1.
- R4: The two-byte colour register (select 3) needs two writes. The first write stores nothing and leaves the pointer unchanged. The second write stores colour {first byte, second byte bit 0} and then the pointer advances as in R3.
- R5: Bit 7 of the second byte is stored as the priority flag only when control bits 5:4 are 01, which are the two Layer 2 palettes (codes 001 and 101). For every other palette the flag is stored as 0.
- R6: A write to the pointer (select 0), the control byte (select 1) or the one-byte colour register returns the two-byte path to its first phase and discards any held first byte.
- R7: Control bits 6:4 choose the palette that is written and read: 000/100 ULA first/second, 001/101 Layer 2 first/second, 010/110 Sprites first/second, 011/111 Tilemap first/second. A write to one palette leaves the same entry in every other palette unchanged.
- R8: A read with select S loads `rdata` at the next clock edge and holds it until the next read. S=0 returns the pointer, S=1 the control byte, S=2 colour bits 8:1, and S=3 the byte {priority, 000000, colour bit 0}. Reads never move the pointer or change the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; loads `rdata` at the next edge |
| reg_sel | input | 2 | Register select: 0 pointer, 1 control, 2 one-byte colour, 3 two-byte colour |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
Assertions check the following on every cycle. The first half of a two-byte write never raises the storage strobe. A write to any other register always leaves the machine in `PH_FIRST`. A committed write with auto-increment enabled moves the pointer by exactly one. The pointer and `rdata` stay stable when no write or read occurs. The storage never receives a set priority flag for a palette that is not Layer 2. The bench's scenarios are the only way to show three things: that the stored colour equals the arithmetic expansion of each written byte across full 256-entry sweeps, that an interrupted two-byte write really discards its held byte, and that each of the eight palettes keeps its own contents.

// File: rtl/palw_pkg.sv
package palw_pkg;
    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_COL8  = 2'd2,
        SEL_COL9  = 2'd3
    } regsel_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    localparam int BYTE_W     = 8;
    localparam int COL_W      = BYTE_W + 1;
    localparam int WORD_W     = COL_W + 1;
    localparam int BANK_LSB   = 4;
    localparam int AUTOINC_OFF_BIT = 7;
    localparam logic [1:0] LAYER2_CODE = 2'b01;
endpackage

// File: rtl/palw_ctrl.sv
module palw_ctrl
    import palw_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int BANK_W = 3,
    localparam int ADDR_W = BANK_W + IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  regsel_e             sel,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [IDX_W-1:0]    idx_q,
    output logic [BYTE_W-1:0]   ctrl_q,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_waddr,
    output logic [WORD_W-1:0]   ram_wdata
);
    phase_e              ph_q, ph_nxt;
    logic [BYTE_W-1:0]   hold_q;
    logic                latch_high;
    logic                commit9;
    logic                commit8;
    logic                is_layer2;
    logic [BANK_W-1:0]   bank;

    assign bank      = ctrl_q[BANK_LSB +: BANK_W];
    assign is_layer2 = (ctrl_q[BANK_LSB +: 2] == LAYER2_CODE);
    assign commit8   = wr_en && (sel == SEL_COL8);

    // next-state logic of the phase machine
    always_comb begin
        ph_nxt     = ph_q;
        latch_high = 1'b0;
        commit9    = 1'b0;
        unique case (ph_q)
            PH_FIRST: begin
                if (wr_en && sel == SEL_COL9) begin
                    latch_high = 1'b1;          // LATCH_HIGH
                    ph_nxt     = PH_SECOND;
                end
            end
            PH_SECOND: begin
                if (wr_en && sel == SEL_COL9) begin
                    commit9 = 1'b1;             // COMMIT
                    ph_nxt  = PH_FIRST;
                end else if (wr_en) begin
                    ph_nxt  = PH_FIRST;         // ABANDON
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_FIRST;
        else        ph_q <= ph_nxt;
    end

    // held first byte, pointer and control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            idx_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (latch_high) hold_q <= wdata;
            if (wr_en && sel == SEL_INDEX) idx_q <= wdata[IDX_W-1:0];
            else if ((commit8 || commit9) && !ctrl_q[AUTOINC_OFF_BIT])
                idx_q <= idx_q + 1'b1;
            if (wr_en && sel == SEL_CTRL) ctrl_q <= wdata;
        end
    end

    // storage write outputs
    always_comb begin
        ram_we    = commit8 || commit9;
        ram_waddr = {bank, idx_q};
        if (commit9)
            ram_wdata = {is_layer2 & wdata[7], hold_q, wdata[0]};
        else
            ram_wdata = {1'b0, wdata, wdata[1] | wdata[0]};
    end

    assert_first_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_FIRST && wr_en && sel == SEL_COL9) |-> !ram_we);

    assert_phase_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel != SEL_COL9) |=> (ph_q == PH_FIRST));

    assert_idx_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !ctrl_q[AUTOINC_OFF_BIT]) |=> (idx_q == $past(idx_q) + 1'b1));

    assert_read_noadv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rd_en) |=> ($stable(idx_q) && $stable(ph_q)));
endmodule

// File: rtl/palw_ram.sv
module palw_ram
    import palw_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int BANK_W = 3,
    localparam int ADDR_W = BANK_W + IDX_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wword,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rword
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wword;
    end

    assign rword = mem[raddr];

    assert_prio_only_l2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr[IDX_W +: 2] != LAYER2_CODE) |-> !wword[WORD_W-1]);
endmodule

// File: rtl/palette_port.sv
module palette_port
    import palw_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int BANK_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] reg_sel,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int ADDR_W = BANK_W + IDX_W;

    regsel_e             sel;
    logic [IDX_W-1:0]    idx;
    logic [BYTE_W-1:0]   ctrl;
    logic                ram_we;
    logic [ADDR_W-1:0]   ram_waddr;
    logic [WORD_W-1:0]   ram_wword;
    logic [WORD_W-1:0]   ram_rword;
    logic [ADDR_W-1:0]   ram_raddr;
    logic [BYTE_W-1:0]   rd_mux;

    assign sel       = regsel_e'(reg_sel);
    assign ram_raddr = {ctrl[BANK_LSB +: BANK_W], idx};

    palw_ctrl #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .sel       (sel),
        .wdata     (wdata),
        .idx_q     (idx),
        .ctrl_q    (ctrl),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wword)
    );

    palw_ram #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wword (ram_wword),
        .raddr (ram_raddr),
        .rword (ram_rword)
    );

    always_comb begin
        unique case (sel)
            SEL_INDEX: rd_mux = BYTE_W'(idx);
            SEL_CTRL:  rd_mux = ctrl;
            SEL_COL8:  rd_mux = ram_rword[COL_W-1:1];
            SEL_COL9:  rd_mux = {ram_rword[WORD_W-1], 6'b0, ram_rword[0]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assert_rdata_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/palette_port_test.sv
module palette_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    palette_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = s;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    function automatic logic [7:0] v8(input int i);
        return 8'((i * 53 + 17) & 255);
    endfunction

    function automatic logic [7:0] w9(input int i);
        return 8'((i * 29 + 3) & 255);
    endfunction

    function automatic logic [7:0] s9(input int i);
        return 8'(((i & 1) << 7) | 8'h7E | ((i >> 1) & 1));
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        check("R1 rdata after reset", rdata, 8'h00);
        rst_n = 1'b1;
        rd(2'd0, v); check("R1 index reset", v, 8'h00);
        rd(2'd1, v); check("R1 control reset", v, 8'h00);

        // R2/R3: one-byte sweep over ULA first palette
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        for (int i = 0; i < 256; i++) wr(2'd2, v8(i));
        rd(2'd0, v); check("R3 wrap to 0", v, 8'h00);
        for (int i = 0; i < 256; i++) begin
            wr(2'd0, 8'(i));
            rd(2'd2, v); check("R2 colour byte", v, v8(i));
            rd(2'd3, v); check("R2 blue lsb, prio clear", v, {7'b0, v8(i)[1] | v8(i)[0]});
        end
        rd(2'd0, v); check("R8 read keeps index", v, 8'hFF);

        // R4/R5: two-byte sweep over Layer 2 first palette (code 001)
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h00);
        for (int i = 0; i < 256; i++) begin
            wr(2'd3, w9(i));
            if (i == 7) begin
                rd(2'd0, v); check("R4 first write holds index", v, 8'd7);
            end
            wr(2'd3, s9(i));
        end
        rd(2'd0, v); check("R4 index after 256 pairs", v, 8'h00);
        for (int i = 0; i < 256; i++) begin
            wr(2'd0, 8'(i));
            rd(2'd2, v); check("R4 colour byte", v, w9(i));
            rd(2'd3, v); check("R5 layer2 prio and lsb", v, {s9(i)[7], 6'b0, s9(i)[0]});
        end

        // R5/R7: sprites first palette (010) drops priority
        wr(2'd1, 8'h20);
        wr(2'd0, 8'd10);
        wr(2'd3, 8'hAA); wr(2'd3, 8'h81);
        wr(2'd0, 8'd10);
        rd(2'd3, v); check("R5 sprites prio dropped", v, 8'h01);
        rd(2'd2, v); check("R7 sprites entry", v, 8'hAA);
        wr(2'd1, 8'h00); wr(2'd0, 8'd10);
        rd(2'd2, v); check("R7 ULA entry intact", v, v8(10));
        wr(2'd1, 8'h10); wr(2'd0, 8'd10);
        rd(2'd2, v); check("R7 layer2 entry intact", v, w9(10));

        // R5/R7: Layer 2 second palette (101) keeps priority
        wr(2'd1, 8'h50);
        rd(2'd1, v); check("R8 control readback", v, 8'h50);
        wr(2'd0, 8'd0);
        wr(2'd3, 8'hF0); wr(2'd3, 8'h81);
        wr(2'd0, 8'd0);
        rd(2'd3, v); check("R5 layer2 second prio", v, 8'h81);
        rd(2'd2, v); check("R7 layer2 second colour", v, 8'hF0);
        wr(2'd1, 8'h10); wr(2'd0, 8'd0);
        rd(2'd2, v); check("R7 layer2 first intact", v, w9(0));

        // R3: auto-increment off
        wr(2'd1, 8'h80);
        wr(2'd0, 8'd200);
        wr(2'd2, 8'h5A);
        rd(2'd0, v); check("R3 no advance one-byte", v, 8'd200);
        rd(2'd2, v); check("R3 entry written", v, 8'h5A);
        wr(2'd3, 8'h11); wr(2'd3, 8'h01);
        rd(2'd0, v); check("R3 no advance two-byte", v, 8'd200);
        rd(2'd2, v); check("R4 entry via pair", v, 8'h11);
        rd(2'd3, v); check("R5 ULA prio zero", v, 8'h01);

        // R6: pointer write abandons held byte
        wr(2'd1, 8'h10);
        wr(2'd0, 8'd40);
        wr(2'd3, 8'h33);
        wr(2'd0, 8'd41);
        wr(2'd3, 8'h44); wr(2'd3, 8'h80);
        rd(2'd0, v); check("R6 index after pair", v, 8'd42);
        wr(2'd0, 8'd41);
        rd(2'd2, v); check("R6 pointer abandon colour", v, 8'h44);
        rd(2'd3, v); check("R6 pointer abandon second", v, 8'h80);
        wr(2'd0, 8'd40);
        rd(2'd2, v); check("R6 abandoned entry intact", v, w9(40));

        // R6: control write abandons held byte
        wr(2'd0, 8'd50);
        wr(2'd3, 8'h55);
        wr(2'd1, 8'h10);
        wr(2'd3, 8'h66); wr(2'd3, 8'h01);
        wr(2'd0, 8'd50);
        rd(2'd2, v); check("R6 control abandon colour", v, 8'h66);
        rd(2'd3, v); check("R6 control abandon second", v, 8'h01);

        // R6: one-byte colour write abandons held byte
        wr(2'd0, 8'd60);
        wr(2'd3, 8'h77);
        wr(2'd2, 8'h12);
        wr(2'd3, 8'h99); wr(2'd3, 8'h00);
        rd(2'd0, v); check("R6 index after mixed writes", v, 8'd62);
        wr(2'd0, 8'd60);
        rd(2'd2, v); check("R2 interrupting byte", v, 8'h12);
        rd(2'd3, v); check("R2 interrupting lsb", v, 8'h01);
        wr(2'd0, 8'd61);
        rd(2'd2, v); check("R6 colour abandon colour", v, 8'h99);
        rd(2'd3, v); check("R6 colour abandon second", v, 8'h00);

        // R8: rdata holds without a read
        repeat (3) @(negedge clk);
        check("R8 rdata held", rdata, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule